// File: doc/BRIEF.md
# Branch Resolution Unit

This unit sits beside the decode stage of a small 16-bit-encoded processor. Each cycle it may receive one fetched instruction word together with that instruction's address, the four condition flags (negative, zero, carry, overflow) and the value of the register named by an indirect branch. It classifies the word as one of four branch forms or as a non-branch. For a branch it decides whether the branch is taken, computes the destination address and, for calls, computes the return address. It never changes the flags.

The instruction word is 32 bits wide. The first fetched halfword sits in bits 31:16. A 16-bit instruction uses only that upper halfword. A 32-bit call pair puts its second halfword in bits 15:0. All results are registered, so they appear one clock after the request. The offset base is the instruction address plus 4.

Top module: `brc_unit`

## Requirements
- R1: Upper halfword `1101 cccc oooooooo` is a conditional short branch. The target is pc+4 plus the 8-bit offset doubled and sign-extended (range -256 to +254). The target is reported whether or not the branch is taken, and no return address is written.
- R2: The condition code cccc is evaluated from the flags. 0000 taken when Z=1; 0001 when Z=0; 0010 when C=1; 0011 when C=0; 0100 when N=1; 0101 when N=0; 0110 when V=1; 0111 when V=0; 1000 when C=1 and Z=0; 1001 when C=0 or Z=1; 1010 when N=V; 1011 when N!=V; 1100 when Z=0 and N=V; 1101 when Z=1 or N!=V.
- R3: Condition code 1110 is always taken. Condition code 1111 is reported as not a branch: isBranch=0, taken=0, target=0.
- R4: Upper halfword `11100` followed by an 11-bit offset is an unconditional branch and is always taken. The target is pc+4 plus the offset doubled and sign-extended (range -2048 to +2046).
- R5: Upper halfword `11110 S imm10` followed by lower halfword `11 J1 1 J2 imm11` is a call. Here I1 = NOT(J1 XOR S) and I2 = NOT(J2 XOR S). The target is pc+4 plus the sign-extended value S:I1:I2:imm10:imm11:0. The return address is (pc+4) with bit 0 set.
- R6: Upper halfword `010001110 mmmm 000` is an indirect branch, and `010001111 mmmm 000` is an indirect call. Both are taken, and the target is regVal with bit 0 cleared. The indirect call writes a return address of (pc+2) with bit 0 set.
- R7: Any other word produces isBranch=0, taken=0, linkWr=0, target=0 and link=0.
- R8: Results appear on the outputs one clock after a request, and outValid follows inValid with that same delay. While reset is held, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| instWord | input | 32 | Instruction word, first halfword in bits 31:16 |
| pc | input | ADDR_W | Address of the instruction |
| regVal | input | ADDR_W | Value of the indirect branch register |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| outValid | output | 1 | Result strobe |
| outIsBranch | output | 1 | Word was a branch form |
| outTaken | output | 1 | Branch is taken |
| outTarget | output | ADDR_W | Destination address |
| outLinkWr | output | 1 | Return address must be written |
| outLink | output | ADDR_W | Return address |

## Verification
The bench builds the unit with the default 32-bit address width. At that width the call's 25-bit offset fills its whole range, and wrap-around of pc plus a negative offset is visible. Random instruction addresses and register values near the top and bottom of the address space reach both sign extremes of every offset form. All sixteen condition codes are run against random flag combinations.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_COND = 3'd1,
    TGT_JUMP = 3'd2,
    TGT_CALL = 3'd3,
    TGT_REG  = 3'd4
  } tgtSel_e;

  typedef struct packed {
    logic    isBranch;
    logic    taken;
    tgtSel_e selTgt;
    logic    linkWr;
    logic    linkStep4;
  } ctl_t;

  localparam logic [3:0] COND_ALWAYS = 4'hE;
  localparam logic [3:0] COND_NEVER  = 4'hF;

  function automatic logic condHolds(input logic [3:0] cc, input logic n,
                                     input logic z, input logic c, input logic v);
    logic r;
    unique case (cc[3:1])
      3'd0: r = z;
      3'd1: r = c;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = c & ~z;
      3'd5: r = (n == v);
      3'd6: r = ~z & (n == v);
      default: r = 1'b1;
    endcase
    if (cc[3:1] != 3'd7 && cc[0]) r = ~r;
    return r;
  endfunction

endpackage

// File: rtl/brc_ctl.sv
module brc_ctl
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instWord,
  input  logic        flagN,
  input  logic        flagZ,
  input  logic        flagC,
  input  logic        flagV,
  output ctl_t        ctl
);

  logic [15:0] hw;
  logic [15:0] lo;
  logic        isCond;
  logic        isJump;
  logic        isCall;
  logic        isRegJ;
  logic        isRegCall;
  logic [3:0]  cc;
  logic        unusedBits;

  assign hw = instWord[31:16];
  assign lo = instWord[15:0];
  assign cc = hw[11:8];
  assign unusedBits = ^{hw[6:3], lo[13], lo[11:0]};

  assign isCond    = (hw[15:12] == 4'b1101) && (cc != COND_NEVER);
  assign isJump    = (hw[15:11] == 5'b11100);
  assign isCall    = (hw[15:11] == 5'b11110) && (lo[15:14] == 2'b11) && lo[12];
  assign isRegJ    = (hw[15:7] == 9'b010001110) && (hw[2:0] == 3'b000);
  assign isRegCall = (hw[15:7] == 9'b010001111) && (hw[2:0] == 3'b000);

  always_comb begin
    ctl = '0;
    ctl.selTgt = TGT_NONE;
    if (isCond) begin
      ctl.isBranch = 1'b1;
      ctl.taken    = condHolds(cc, flagN, flagZ, flagC, flagV);
      ctl.selTgt   = TGT_COND;
    end else if (isJump) begin
      ctl.isBranch = 1'b1;
      ctl.taken    = 1'b1;
      ctl.selTgt   = TGT_JUMP;
    end else if (isCall) begin
      ctl.isBranch  = 1'b1;
      ctl.taken     = 1'b1;
      ctl.selTgt    = TGT_CALL;
      ctl.linkWr    = 1'b1;
      ctl.linkStep4 = 1'b1;
    end else if (isRegJ || isRegCall) begin
      ctl.isBranch = 1'b1;
      ctl.taken    = 1'b1;
      ctl.selTgt   = TGT_REG;
      ctl.linkWr   = isRegCall;
    end
  end

  // R3: code 1110 is taken regardless of flags
  p_always_taken_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && hw[15:12] == 4'b1101 && cc == COND_ALWAYS) |-> (ctl.taken && ctl.isBranch));

  // R3: code 1111 never counts as a branch
  p_never_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && hw[15:12] == 4'b1101 && cc == COND_NEVER) |-> !ctl.isBranch);

endmodule

// File: rtl/brc_dp.sv
module brc_dp
  import brc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] regVal,
  input  ctl_t              ctl,
  output logic              outValid,
  output logic              outIsBranch,
  output logic              outTaken,
  output logic [ADDR_W-1:0] outTarget,
  output logic              outLinkWr,
  output logic [ADDR_W-1:0] outLink
);

  localparam int COND_OFF_W = 9;
  localparam int JUMP_OFF_W = 12;
  localparam int CALL_OFF_W = 25;

  logic [15:0]           hw;
  logic [15:0]           lo;
  logic [ADDR_W-1:0]     pcBase;
  logic [ADDR_W-1:0]     pcNext2;
  logic [COND_OFF_W-1:0] rawCond;
  logic [JUMP_OFF_W-1:0] rawJump;
  logic [CALL_OFF_W-1:0] rawCall;
  logic [ADDR_W-1:0]     offCond;
  logic [ADDR_W-1:0]     offJump;
  logic [ADDR_W-1:0]     offCall;
  logic                  sBit;
  logic                  iOne;
  logic                  iTwo;
  logic [ADDR_W-1:0]     nextTarget;
  logic [ADDR_W-1:0]     nextLink;
  logic                  unusedBits;

  assign hw = instWord[31:16];
  assign lo = instWord[15:0];
  assign unusedBits = ^{hw[15:11], lo[15:14], lo[12]};

  assign pcBase  = pc + ADDR_W'(4);
  assign pcNext2 = pc + ADDR_W'(2);

  assign sBit = hw[10];
  assign iOne = ~(lo[13] ^ sBit);
  assign iTwo = ~(lo[11] ^ sBit);

  assign rawCond = {hw[7:0], 1'b0};
  assign rawJump = {hw[10:0], 1'b0};
  assign rawCall = {sBit, iOne, iTwo, hw[9:0], lo[10:0], 1'b0};

  assign offCond = {{(ADDR_W-COND_OFF_W){rawCond[COND_OFF_W-1]}}, rawCond};
  assign offJump = {{(ADDR_W-JUMP_OFF_W){rawJump[JUMP_OFF_W-1]}}, rawJump};
  assign offCall = {{(ADDR_W-CALL_OFF_W){rawCall[CALL_OFF_W-1]}}, rawCall};

  always_comb begin
    unique case (ctl.selTgt)
      TGT_COND: nextTarget = pcBase + offCond;
      TGT_JUMP: nextTarget = pcBase + offJump;
      TGT_CALL: nextTarget = pcBase + offCall;
      TGT_REG:  nextTarget = regVal & ~ADDR_W'(1);
      default:  nextTarget = '0;
    endcase
  end

  always_comb begin
    if (!ctl.linkWr)        nextLink = '0;
    else if (ctl.linkStep4) nextLink = pcBase | ADDR_W'(1);
    else                    nextLink = pcNext2 | ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outIsBranch <= 1'b0;
      outTaken    <= 1'b0;
      outTarget   <= '0;
      outLinkWr   <= 1'b0;
      outLink     <= '0;
    end else begin
      outValid    <= inValid;
      outIsBranch <= inValid & ctl.isBranch;
      outTaken    <= inValid & ctl.taken;
      outTarget   <= inValid ? nextTarget : '0;
      outLinkWr   <= inValid & ctl.linkWr;
      outLink     <= inValid ? nextLink : '0;
    end
  end

  // R5/R6: a written return address always has bit 0 set
  p_link_odd_r5: assert property (@(posedge clk) disable iff (!rstN)
    outLinkWr |-> outLink[0]);

  // R6: indirect targets leave with bit 0 cleared
  p_reg_target_even_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.selTgt == TGT_REG) |=> (outTarget[0] == 1'b0 && outTaken));

  // R7: a non-branch result is quiet
  p_quiet_nonbranch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIsBranch) |-> (!outTaken && !outLinkWr && outLink == '0));

  // R8: result strobe trails the request by one clock
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8: nothing is reported without a request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outTaken && !outIsBranch && !outLinkWr));

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] regVal,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  output logic              outValid,
  output logic              outIsBranch,
  output logic              outTaken,
  output logic [ADDR_W-1:0] outTarget,
  output logic              outLinkWr,
  output logic [ADDR_W-1:0] outLink
);

  ctl_t ctl;

  brc_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .instWord (instWord),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV),
    .ctl      (ctl)
  );

  brc_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .instWord    (instWord),
    .pc          (pc),
    .regVal      (regVal),
    .ctl         (ctl),
    .outValid    (outValid),
    .outIsBranch (outIsBranch),
    .outTaken    (outTaken),
    .outTarget   (outTarget),
    .outLinkWr   (outLinkWr),
    .outLink     (outLink)
  );

endmodule

// File: tb/brc_unit_bench.sv
module brc_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] pc = '0;
  logic [31:0] regVal = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic        outValid, outIsBranch, outTaken, outLinkWr;
  logic [31:0] outTarget, outLink;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brc_unit #(.ADDR_W(32)) u_brc_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instWord(instWord),
    .pc(pc), .regVal(regVal), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .outValid(outValid), .outIsBranch(outIsBranch),
    .outTaken(outTaken), .outTarget(outTarget), .outLinkWr(outLinkWr),
    .outLink(outLink)
  );

  function automatic logic condModel(input logic [3:0] cc, input logic n,
                                     input logic z, input logic c, input logic v);
    case (cc)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic model(input logic [31:0] w, input logic [31:0] p, input logic [31:0] r,
                       output logic eBr, output logic eTk, output logic [31:0] eTg,
                       output logic eLw, output logic [31:0] eLk, output string tag);
    logic [15:0] h, l;
    logic s, i1, i2;
    h = w[31:16]; l = w[15:0];
    eBr = 0; eTk = 0; eTg = 0; eLw = 0; eLk = 0; tag = "R7";
    if (h[15:12] == 4'b1101) begin
      tag = (h[11:8] >= 4'hE) ? "R3" : "R2";
      if (h[11:8] != 4'hF) begin
        eBr = 1;
        eTk = condModel(h[11:8], flagN, flagZ, flagC, flagV);
        eTg = p + 32'd4 + {{23{h[7]}}, h[7:0], 1'b0};
      end
    end else if (h[15:11] == 5'b11100) begin
      tag = "R4";
      eBr = 1; eTk = 1;
      eTg = p + 32'd4 + {{20{h[10]}}, h[10:0], 1'b0};
    end else if (h[15:11] == 5'b11110 && l[15:14] == 2'b11 && l[12]) begin
      tag = "R5";
      s = h[10]; i1 = !(l[13] ^ s); i2 = !(l[11] ^ s);
      eBr = 1; eTk = 1; eLw = 1;
      eTg = p + 32'd4 + {{7{s}}, s, i1, i2, h[9:0], l[10:0], 1'b0};
      eLk = (p + 32'd4) | 32'd1;
    end else if (h[15:8] == 8'b01000111 && h[2:0] == 3'b000) begin
      tag = "R6";
      eBr = 1; eTk = 1;
      eTg = {r[31:1], 1'b0};
      if (h[7]) begin eLw = 1; eLk = (p + 32'd2) | 32'd1; end
    end
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runOne(input logic [31:0] w, input logic [31:0] p, input logic [31:0] r,
                        input logic [3:0] nzcv);
    logic eBr, eTk, eLw;
    logic [31:0] eTg, eLk;
    string tag;
    inValid = 1; instWord = w; pc = p; regVal = r;
    {flagN, flagZ, flagC, flagV} = nzcv;
    model(w, p, r, eBr, eTk, eTg, eLw, eLk, tag);
    @(negedge clk);
    cmp("R8", "valid", {31'd0, outValid}, 32'd1);
    cmp(tag, "isBranch", {31'd0, outIsBranch}, {31'd0, eBr});
    cmp(tag, "taken", {31'd0, outTaken}, {31'd0, eTk});
    cmp(tag, "target", outTarget, eTg);
    cmp(tag, "linkWr", {31'd0, outLinkWr}, {31'd0, eLw});
    cmp(tag, "link", outLink, eLk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R8: reset state
    cmp("R8", "reset valid", {31'd0, outValid}, 32'd0);
    cmp("R8", "reset target", outTarget, 32'd0);
    cmp("R8", "reset link", outLink, 32'd0);
    rstN = 1;
    @(negedge clk);

    // R1/R2: EQ taken with Z set, most negative offset
    runOne(32'hD080_0000, 32'h0000_1000, 32'h0, 4'b0100);
    // R1/R2: NE not taken with Z set, target still reported, max positive
    runOne(32'hD17F_0000, 32'h0000_1000, 32'h0, 4'b0100);
    // R2: GT with N!=V not taken
    runOne(32'hDC05_0000, 32'h0000_2000, 32'h0, 4'b1000);
    // R3: always code and never code
    runOne(32'hDE10_0000, 32'h0000_3000, 32'h0, 4'b0000);
    runOne(32'hDF10_0000, 32'h0000_3000, 32'h0, 4'b1111);
    // R4: extremes of the unconditional range
    runOne(32'hE3FF_0000, 32'h0000_4000, 32'h0, 4'b0000);
    runOne(32'hE400_0000, 32'h0000_4000, 32'h0, 4'b0000);
    // R5: call with S=0, J1=J2=1 and with S=1, J1=J2=0
    runOne(32'hF000_F802, 32'h0000_5000, 32'h0, 4'b0000);
    runOne(32'hF7FF_D7FF, 32'h0100_0000, 32'h0, 4'b0000);
    // R6: indirect branch and indirect call, odd register value
    runOne(32'h4770_0000, 32'h0000_6000, 32'h0000_2001, 4'b0000);
    runOne(32'h4788_0000, 32'h0000_6002, 32'hFFFF_FFFF, 4'b0000);
    // R7: non-branch word
    runOne(32'hBF00_0000, 32'h0000_7000, 32'h1234_5679, 4'b1111);
    // R7: indirect form with nonzero low field is not a branch
    runOne(32'h4771_0000, 32'h0000_7000, 32'h1234_5679, 4'b0000);

    // R8: idle cycle produces no result
    inValid = 0;
    @(negedge clk);
    cmp("R8", "idle valid", {31'd0, outValid}, 32'd0);
    cmp("R8", "idle taken", {31'd0, outTaken}, 32'd0);

    // Random mix across all forms
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] w, p, r;
      logic [15:0] h, l;
      h = 16'($urandom); l = 16'($urandom);
      case ($urandom % 6)
        0: h[15:12] = 4'b1101;
        1: h[15:11] = 5'b11100;
        2: begin h[15:11] = 5'b11110; l[15:14] = 2'b11; l[12] = 1'b1; end
        3: begin h[15:8] = 8'b01000111; h[2:0] = 3'b000; end
        4: begin h[15:8] = 8'b01000111; end
        default: ;
      endcase
      w = {h, l};
      p = $urandom & 32'hFFFF_FFFE;
      r = $urandom;
      runOne(w, p, r, 4'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule